// File: doc/BRIEF.md
# Auto-Incrementing Packet Data Port

This block gives a host byte-wide access to packet buffer pages through a 16-bit pointer and a four-byte data window. The pointer holds an 11-bit byte offset, a page-source bit and a step-mode bit. The page-source bit chooses between the page at the head of the receive queue and the page named by the packet-number value. The allocator supplies both page numbers as inputs. The packet pages are an internal RAM of this block.

In step mode every data window access, read or write, advances the offset by one. The offset wraps inside 11 bits and the upper five pointer bits keep their values. Without step mode the pointer does not move, and the byte reached is the offset plus the lane number of the window address. This lets the host reach four neighbouring bytes without rewriting the pointer. The pointer is loaded one byte at a time. Read data comes back registered, one cycle after the request.

Top module: `dport_top`

## Requirements
- R1: After reset the pointer is zero: both pointer bytes read back as 0x00.
- R2: A write to address 0 replaces pointer bits 7:0 and a write to address 1 replaces pointer bits 15:8; in each case the other byte keeps its value.
- R3: A read of address 1 returns pointer bits 15:8 with bit 3 of that byte (pointer bit 11) forced to 0. A read of address 0 returns pointer bits 7:0 unchanged.
- R4: Pointer bit 15 set addresses the page given by `rxq_head`; bit 15 clear addresses the page given by `pkt_num`. Data stored through one page source is not visible through the other page.
- R5: With pointer bit 14 set, each access (read or write) to the data window at addresses 4 to 7 first uses offset bits 10:0 and then adds one to them. The sum wraps from 0x7FF to 0x000, and bits 15:11 stay unchanged.
- R6: With pointer bit 14 clear, a data window access leaves the pointer unchanged. It reaches byte (offset + address bits 1:0) modulo 2048.
- R7: A read request (`host_req` high, `host_we` low) gives `host_rvalid` high for exactly the next cycle, with the read byte on `host_rdata`. A write request never raises `host_rvalid`.
- R8: Addresses 2 and 3 are reserved. Writes to them change neither the pointer nor the pages, and reads of them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access strobe, one access per cycle |
| host_we | input | 1 | 1 for a write, 0 for a read |
| host_addr | input | 3 | 0/1 pointer low/high byte, 2/3 reserved, 4 to 7 data window |
| host_wdata | input | 8 | Write byte |
| rxq_head | input | PG_W | Page at the head of the receive queue |
| pkt_num | input | PG_W | Page held in the packet-number value |
| host_rdata | output | 8 | Read byte, valid while host_rvalid is high |
| host_rvalid | output | 1 | Read data valid, one cycle after a read request |

## Verification
On every cycle the assertions check the pointer's register behaviour. They cover byte-wise loading that keeps the other half, the step increment with its 11-bit wrap and fixed upper bits, the frozen pointer in lane mode, reserved writes that leave the pointer alone, the masked high-byte readback and the one-cycle valid pulse. Other behaviours show only in the bench's write-then-read scenarios: which page a pointer setting reaches, which byte a lane adds up to, and whether data lands at the wrapped offset. All of these depend on the RAM contents.

// File: rtl/dport_pkg.sv
package dport_pkg;

    localparam int OFF_W   = 11;
    localparam int DATA_W  = 8;
    localparam int HADDR_W = 3;
    localparam int LANE_W  = 2;
    localparam logic [DATA_W-1:0] HI_RD_MASK = 8'hF7;

    // Pointer layout; bit positions are visible to the host.
    typedef struct packed {
        logic             from_rxq;  // bit 15
        logic             step;      // bit 14
        logic [2:0]       resv;      // bits 13:11
        logic [OFF_W-1:0] off;       // bits 10:0
    } dptr_t;

    typedef enum logic [1:0] {
        HS_PTR_LO,
        HS_PTR_HI,
        HS_WIN,
        HS_NONE
    } hsel_e;

    function automatic hsel_e hsel_decode(input logic [HADDR_W-1:0] a);
        hsel_e r;
        if (a[2])              r = HS_WIN;
        else if (a == 3'd0)    r = HS_PTR_LO;
        else if (a == 3'd1)    r = HS_PTR_HI;
        else                   r = HS_NONE;
        return r;
    endfunction

endpackage

// File: rtl/dport_ptr.sv
module dport_ptr
    import dport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  hsel_e             sel,
    input  logic [DATA_W-1:0] wdata,
    output dptr_t             ptr_q
);

    dptr_t ptr_d;
    dptr_t ptr_r;

    always_comb begin
        ptr_d = ptr_r;
        if (req) begin
            unique case (sel)
                HS_PTR_LO: if (we) ptr_d[7:0]  = wdata;
                HS_PTR_HI: if (we) ptr_d[15:8] = wdata;
                HS_WIN:    if (ptr_r.step) ptr_d.off = ptr_r.off + OFF_W'(1);
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_r <= '0;
        else        ptr_r <= ptr_d;
    end

    assign ptr_q = ptr_r;

endmodule

// File: rtl/dport_addr.sv
module dport_addr
    import dport_pkg::*;
#(
    parameter int PG_W = 1
) (
    input  logic              from_rxq,
    input  logic              step,
    input  logic [OFF_W-1:0]  off,
    input  logic [LANE_W-1:0] lane,
    input  logic [PG_W-1:0]   rxq_head,
    input  logic [PG_W-1:0]   pkt_num,
    output logic [PG_W-1:0]   page,
    output logic [OFF_W-1:0]  byte_off
);

    always_comb begin
        page     = from_rxq ? rxq_head : pkt_num;
        byte_off = step ? off : off + OFF_W'(lane);
    end

endmodule

// File: rtl/dport_ram.sv
module dport_ram
    import dport_pkg::*;
#(
    parameter int PG_W = 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [PG_W-1:0]   page,
    input  logic [OFF_W-1:0]  byte_off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int IDX_W = PG_W + OFF_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;
    logic [IDX_W-1:0]  idx;

    assign idx = {page, byte_off};

    always_ff @(posedge clk) begin
        if (wr_en) mem[idx] <= wdata;
        if (rd_en) rd_q <= mem[idx];
    end

    assign rdata = rd_q;

endmodule

// File: rtl/dport_top.sv
module dport_top
    import dport_pkg::*;
#(
    parameter int NUM_PAGES = 2,
    localparam int PG_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    input  logic [PG_W-1:0]    rxq_head,
    input  logic [PG_W-1:0]    pkt_num,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               host_rvalid
);

    typedef struct packed {
        logic              rvalid;
        logic              from_ram;
        logic [DATA_W-1:0] bval;
    } rsp_t;

    hsel_e             sel;
    dptr_t             ptr_q;
    logic [PG_W-1:0]   page;
    logic [OFF_W-1:0]  byte_off;
    logic              win_acc;
    logic [DATA_W-1:0] ram_rdata;
    rsp_t              rsp_d;
    rsp_t              rsp_q;

    assign sel     = hsel_decode(host_addr);
    assign win_acc = host_req && (sel == HS_WIN);

    dport_ptr u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (host_req),
        .we    (host_we),
        .sel   (sel),
        .wdata (host_wdata),
        .ptr_q (ptr_q)
    );

    dport_addr #(.PG_W(PG_W)) u_addr (
        .from_rxq (ptr_q.from_rxq),
        .step     (ptr_q.step),
        .off      (ptr_q.off),
        .lane     (host_addr[LANE_W-1:0]),
        .rxq_head (rxq_head),
        .pkt_num  (pkt_num),
        .page     (page),
        .byte_off (byte_off)
    );

    dport_ram #(.PG_W(PG_W)) u_ram (
        .clk      (clk),
        .wr_en    (win_acc && host_we),
        .rd_en    (win_acc && !host_we),
        .page     (page),
        .byte_off (byte_off),
        .wdata    (host_wdata),
        .rdata    (ram_rdata)
    );

    always_comb begin
        rsp_d          = '0;
        rsp_d.rvalid   = host_req && !host_we;
        rsp_d.from_ram = sel == HS_WIN;
        unique case (sel)
            HS_PTR_LO: rsp_d.bval = ptr_q[7:0];
            HS_PTR_HI: rsp_d.bval = ptr_q[15:8] & HI_RD_MASK;
            default:   rsp_d.bval = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign host_rvalid = rsp_q.rvalid;
    assign host_rdata  = !rsp_q.rvalid ? '0 :
                         (rsp_q.from_ram ? ram_rdata : rsp_q.bval);

endmodule

// File: rtl/dport_chk.sv
module dport_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req,
    input logic        we,
    input logic [2:0]  addr,
    input logic [7:0]  wdata,
    input logic [15:0] ptr,
    input logic [7:0]  rdata,
    input logic        rvalid
);

    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ptr == 16'h0000);

    p_lo_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && addr == 3'd0) |=>
        (ptr[7:0] == $past(wdata) && ptr[15:8] == $past(ptr[15:8])));

    p_hi_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && addr == 3'd1) |=>
        (ptr[15:8] == $past(wdata) && ptr[7:0] == $past(ptr[7:0])));

    p_hi_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && addr == 3'd1) |=> (rdata[3] == 1'b0));

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && addr[2] && ptr[14]) |=>
        (ptr[15:11] == $past(ptr[15:11]) &&
         ptr[10:0] == $past(ptr[10:0]) + 11'd1));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && addr[2] && !ptr[14]) |=> $stable(ptr));

    p_rvalid_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we) |=> rvalid);

    p_rvalid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && !we) |=> !rvalid);

    p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && addr[2:1] == 2'b01) |=> $stable(ptr));

endmodule

bind dport_top dport_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (host_req),
    .we     (host_we),
    .addr   (host_addr),
    .wdata  (host_wdata),
    .ptr    (ptr_q),
    .rdata  (host_rdata),
    .rvalid (host_rvalid)
);

// File: tb/tb_dport_top.sv
module tb_dport_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_req = 1'b0;
    logic       host_we = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [0:0] rxq_head = 1'b0;
    logic [0:0] pkt_num = 1'b1;
    logic [7:0] host_rdata;
    logic       host_rvalid;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    dport_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .rxq_head   (rxq_head),
        .pkt_num    (pkt_num),
        .host_rdata (host_rdata),
        .host_rvalid(host_rvalid)
    );

    // {we, addr[2:0], byte}: byte is write data or expected read data.
    // Page source: pkt_num = 1, rxq_head = 0.
    localparam int NV = 33;
    localparam logic [11:0] VEC [NV] = '{
        {1'b1, 3'd0, 8'h10},  // R2 low byte
        {1'b1, 3'd1, 8'h40},  // R2 high byte, step mode
        {1'b0, 3'd0, 8'h10},
        {1'b0, 3'd1, 8'h40},
        {1'b1, 3'd4, 8'hA1},  // R5 page1 0x010
        {1'b1, 3'd5, 8'hB2},  // R5 0x011
        {1'b1, 3'd6, 8'hC3},  // R5 0x012
        {1'b0, 3'd0, 8'h13},  // R5 three steps
        {1'b1, 3'd0, 8'h10},
        {1'b0, 3'd7, 8'hA1},  // R5 lane ignored in step mode
        {1'b0, 3'd4, 8'hB2},
        {1'b0, 3'd0, 8'h12},  // R5 reads step too
        {1'b1, 3'd1, 8'h00},  // R6 lane mode
        {1'b1, 3'd0, 8'h10},
        {1'b0, 3'd6, 8'hC3},  // R6 0x010+2
        {1'b0, 3'd5, 8'hB2},  // R6 0x010+1
        {1'b0, 3'd0, 8'h10},  // R6 pointer held
        {1'b1, 3'd7, 8'h5D},  // R6 0x013
        {1'b0, 3'd7, 8'h5D},
        {1'b1, 3'd1, 8'h88},  // R4 receive page, bit 11 set
        {1'b0, 3'd1, 8'h80},  // R3 bit 3 masked
        {1'b1, 3'd4, 8'h77},  // R4 page0 0x010
        {1'b1, 3'd1, 8'h00},
        {1'b0, 3'd4, 8'hA1},  // R4 page1 untouched
        {1'b1, 3'd1, 8'h80},
        {1'b0, 3'd4, 8'h77},  // R4 page0 data
        {1'b1, 3'd2, 8'hFF},  // R8 reserved write
        {1'b0, 3'd0, 8'h10},  // R8 pointer unchanged
        {1'b0, 3'd1, 8'h80},
        {1'b0, 3'd3, 8'h00},  // R8 reserved read
        {1'b1, 3'd1, 8'h08},  // R3 bit 11 outside the offset
        {1'b0, 3'd4, 8'hA1},
        {1'b0, 3'd1, 8'h00}
    };

    function automatic string tag_of(input logic [2:0] a);
        if (a == 3'd0)      return "R2";
        else if (a == 3'd1) return "R3";
        else if (a[2])      return "R5";
        else                return "R8";
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // One access; returns the response sampled one cycle later.
    task automatic acc(input logic we, input logic [2:0] a, input logic [7:0] d,
                       output logic [7:0] rd);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
        rd = host_rdata;
        check("R7 rvalid", {7'd0, host_rvalid}, {7'd0, !we});
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] r;
        acc(1'b0, a, 8'h00, r);
        check(req, r, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] r;
        acc(1'b1, a, d, r);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 idle rvalid", {7'd0, host_rvalid}, 8'h00);
        rd_chk("R1 low", 3'd0, 8'h00);
        rd_chk("R1 high", 3'd1, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [7:0] r;
            acc(VEC[i][11], VEC[i][10:8], VEC[i][7:0], r);
            if (!VEC[i][11]) check(tag_of(VEC[i][10:8]), r, VEC[i][7:0]);
        end

        // R5 wrap: step mode at 0x7FF
        wr(3'd0, 8'hFF);
        wr(3'd1, 8'h47);
        wr(3'd4, 8'h3C);
        rd_chk("R5 wrap low", 3'd0, 8'h00);
        rd_chk("R5 wrap high", 3'd1, 8'h40);
        wr(3'd5, 8'h9E);
        rd_chk("R5 after wrap", 3'd0, 8'h01);
        // R6 wrap: lane sum past 0x7FF
        wr(3'd1, 8'h07);
        wr(3'd0, 8'hFF);
        rd_chk("R6 last byte", 3'd4, 8'h3C);
        rd_chk("R6 lane wrap", 3'd5, 8'h9E);
        rd_chk("R6 held", 3'd0, 8'hFF);

        // R1 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk("R1 after reset low", 3'd0, 8'h00);
        rd_chk("R1 after reset high", 3'd1, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule